// File: doc/BRIEF.md
# Latency-Padded Request/Response Bridge

This block sits between an upstream requester and a downstream memory target. Requests flow downstream through one queue and responses flow back upstream through another. Every packet is held inside the bridge for a fixed minimum number of cycles. All four sides use valid/ready handshakes. A packet carries an address, a write flag, a needs-response flag and a data word. Responses carry an address, a write flag and a data word.

Only requests whose address falls inside one of a parameter-configured set of windows are forwarded. Any other request is taken, discarded and flagged. Before a request that expects a response is taken, the bridge reserves one slot in its response queue. A full response side therefore never stalls the downstream target. When a request has to be refused for lack of space, the bridge remembers the refusal. It then raises a one-cycle retry hint as soon as room returns.

Top module: `dly_bridge`

## Requirements
- R1: A request taken at clock edge A is first presented on `dn_req_valid` in the cycle following edge A+DELAY-1, and never earlier. The default DELAY is 3.
- R2: A response taken from downstream at edge P is first presented on `up_rsp_valid` in the cycle following edge P+DELAY-1, and never earlier.
- R3: `up_req_ready` is low for an in-window request while the request queue holds REQ_LIMIT entries. The default REQ_LIMIT is 4.
- R4: An in-window request with `up_req_needs_resp`=1 is refused while the reservation count equals RESP_LIMIT. The default RESP_LIMIT is 2. A request with `up_req_needs_resp`=0 is not affected by the reservation count.
- R5: The reservation count rises on the edge where an in-window needs-response request is taken. It falls only on the edge where a response is handed upstream, not when that response enters the bridge.
- R6: A refused request sets a pending flag. `up_retry` is then high for exactly one cycle: the first cycle in which the request queue is below REQ_LIMIT and the reservation count is below RESP_LIMIT.
- R7: While the downstream side holds ready low, the head packet keeps `dn_req_valid` high and its fields stay unchanged.
- R8: An address hits when WIN_LO[i] <= addr <= WIN_HI[i] for some window i. The defaults are 0x0000–0x0FFF and 0x8000–0x80FF.
- R9: A request that misses every window is taken (`up_req_ready`=1 even when both queues are full) and is never forwarded. It makes no reservation. `up_range_err` is high for the one cycle after the edge that took it.
- R10: Both queues are first-in first-out. Requests leave downstream, and responses leave upstream, in the order they entered.
- R11: After reset both queues are empty, the reservation count is zero, `up_req_ready` is high, and `up_retry` and `up_range_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Bridge can take the request |
| up_req_addr | input | AW | Request address |
| up_req_write | input | 1 | Request is a write |
| up_req_needs_resp | input | 1 | Request expects a response |
| up_req_data | input | DW | Request data word |
| up_retry | output | 1 | One-cycle hint that a refused request may now be taken |
| up_range_err | output | 1 | One-cycle flag for a dropped out-of-window request |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Target takes the request |
| dn_req_addr | output | AW | Forwarded address |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_needs_resp | output | 1 | Forwarded needs-response flag |
| dn_req_data | output | DW | Forwarded data |
| dn_rsp_valid | input | 1 | Target response valid |
| dn_rsp_ready | output | 1 | Bridge takes the response |
| dn_rsp_addr | input | AW | Response address |
| dn_rsp_write | input | 1 | Response write flag |
| dn_rsp_data | input | DW | Response data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Requester takes the response |
| up_rsp_addr | output | AW | Returned address |
| up_rsp_write | output | 1 | Returned write flag |
| up_rsp_data | output | DW | Returned data |

## Verification
The bench drives inputs and samples outputs on falling edges, and counts rising edges from the handshake edge. A forwarded request or response is due on the DELAY-th falling edge after the edge that took it. The bench checks that it is absent on every earlier falling edge. `up_range_err` is checked on the first falling edge after the taking edge and must be low on the second. `up_retry` is checked on the first falling edge after the edge that frees space, and must be low one cycle later. `up_req_ready` is combinational on the request fields, so it is read 1 time unit after those fields change.

// File: rtl/dly_bridge_pkg.sv
package dly_bridge_pkg;
   localparam int STAMP_W = 32;
   typedef logic [STAMP_W-1:0] stamp_t;

   // wrap-safe "now has reached release time"
   function automatic logic stamp_due(input stamp_t now, input stamp_t rel);
      stamp_t diff;
      diff = now - rel;
      return !diff[STAMP_W-1];
   endfunction
endpackage

// File: rtl/dly_win_match.sv
module dly_win_match #(
   parameter int AW      = 16,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN*AW-1:0] WIN_LO = '0,
   parameter logic [NUM_WIN*AW-1:0] WIN_HI = '1
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic [NUM_WIN-1:0] hit_vec;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      assign hit_vec[i] = (addr >= WIN_LO[i*AW +: AW]) && (addr <= WIN_HI[i*AW +: AW]);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/dly_resv_ctr.sv
module dly_resv_ctr #(
   parameter int LIMIT = 2,
   localparam int CW = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic          full,
   output logic [CW-1:0] level
);
   logic [CW-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else begin
         case ({take, give})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign level = lvl_q;
   assign full  = (lvl_q == CW'(LIMIT));

   p_resv_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= CW'(LIMIT));
   p_give_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> (lvl_q != '0));
endmodule

// File: rtl/dly_stamp_fifo.sv
module dly_stamp_fifo
   import dly_bridge_pkg::*;
#(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int DELAY = 1,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stamp_t        now,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic          out_valid,
   output logic [W-1:0]  out_data,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem_q [DEPTH];
   stamp_t        rel_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         mem_q[wp_q] <= push_data;
         rel_q[wp_q] <= now + stamp_t'(DELAY);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= step(wp_q);
         if (pop)  rp_q <= step(rp_q);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign out_valid = (cnt_q != '0) && stamp_due(now, rel_q[rp_q]);
   assign out_data  = mem_q[rp_q];
   assign count     = cnt_q;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CW'(DEPTH)));
   p_pop_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> out_valid);
   p_hold_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !pop) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dly_bridge.sv
module dly_bridge
   import dly_bridge_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 32,
   parameter int DELAY      = 3,
   parameter int REQ_LIMIT  = 4,
   parameter int RESP_LIMIT = 2,
   parameter int NUM_WIN    = 2,
   parameter logic [NUM_WIN*AW-1:0] WIN_LO = {16'h8000, 16'h0000},
   parameter logic [NUM_WIN*AW-1:0] WIN_HI = {16'h80FF, 16'h0FFF}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up_req_valid,
   output logic          up_req_ready,
   input  logic [AW-1:0] up_req_addr,
   input  logic          up_req_write,
   input  logic          up_req_needs_resp,
   input  logic [DW-1:0] up_req_data,
   output logic          up_retry,
   output logic          up_range_err,
   output logic          dn_req_valid,
   input  logic          dn_req_ready,
   output logic [AW-1:0] dn_req_addr,
   output logic          dn_req_write,
   output logic          dn_req_needs_resp,
   output logic [DW-1:0] dn_req_data,
   input  logic          dn_rsp_valid,
   output logic          dn_rsp_ready,
   input  logic [AW-1:0] dn_rsp_addr,
   input  logic          dn_rsp_write,
   input  logic [DW-1:0] dn_rsp_data,
   output logic          up_rsp_valid,
   input  logic          up_rsp_ready,
   output logic [AW-1:0] up_rsp_addr,
   output logic          up_rsp_write,
   output logic [DW-1:0] up_rsp_data
);
   localparam int REQ_W = AW + DW + 2;
   localparam int RSP_W = AW + DW + 1;
   localparam int QCW   = $clog2(REQ_LIMIT + 1);
   localparam int RCW   = $clog2(RESP_LIMIT + 1);

   initial begin
      assert (DELAY >= 1)      else $error("DELAY must be at least 1");
      assert (REQ_LIMIT >= 1)  else $error("REQ_LIMIT must be at least 1");
      assert (RESP_LIMIT >= 1) else $error("RESP_LIMIT must be at least 1");
      assert (NUM_WIN >= 1)    else $error("NUM_WIN must be at least 1");
   end

   stamp_t           now_q;
   logic             hit, accept, req_push, req_pop, rsp_push, rsp_pop;
   logic             req_space, rsp_space, space_ok, resv_full;
   logic             pend_q, err_q;
   logic [QCW-1:0]   req_cnt;
   logic [RCW-1:0]   rsp_cnt, resv_lvl;
   logic [REQ_W-1:0] req_head;
   logic [RSP_W-1:0] rsp_head;

   always_ff @(posedge clk) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + 1'b1;
   end

   dly_win_match #(.AW(AW), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
      .addr (up_req_addr),
      .hit  (hit)
   );

   assign req_space    = (req_cnt < QCW'(REQ_LIMIT));
   assign rsp_space    = !resv_full;
   assign space_ok     = req_space && rsp_space;
   assign up_req_ready = !hit || (req_space && (!up_req_needs_resp || rsp_space));
   assign accept       = up_req_valid && up_req_ready;
   assign req_push     = accept && hit;
   assign req_pop      = dn_req_valid && dn_req_ready;
   assign dn_rsp_ready = (rsp_cnt < RCW'(RESP_LIMIT));
   assign rsp_push     = dn_rsp_valid && dn_rsp_ready;
   assign rsp_pop      = up_rsp_valid && up_rsp_ready;

   dly_resv_ctr #(.LIMIT(RESP_LIMIT)) u_resv (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (req_push && up_req_needs_resp),
      .give  (rsp_pop),
      .full  (resv_full),
      .level (resv_lvl)
   );

   dly_stamp_fifo #(.W(REQ_W), .DEPTH(REQ_LIMIT), .DELAY(DELAY)) u_reqq (
      .clk       (clk),
      .rst_n     (rst_n),
      .now       (now_q),
      .push      (req_push),
      .push_data ({up_req_addr, up_req_write, up_req_needs_resp, up_req_data}),
      .pop       (req_pop),
      .out_valid (dn_req_valid),
      .out_data  (req_head),
      .count     (req_cnt)
   );

   dly_stamp_fifo #(.W(RSP_W), .DEPTH(RESP_LIMIT), .DELAY(DELAY)) u_rspq (
      .clk       (clk),
      .rst_n     (rst_n),
      .now       (now_q),
      .push      (rsp_push),
      .push_data ({dn_rsp_addr, dn_rsp_write, dn_rsp_data}),
      .pop       (rsp_pop),
      .out_valid (up_rsp_valid),
      .out_data  (rsp_head),
      .count     (rsp_cnt)
   );

   assign {dn_req_addr, dn_req_write, dn_req_needs_resp, dn_req_data} = req_head;
   assign {up_rsp_addr, up_rsp_write, up_rsp_data} = rsp_head;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= accept && !hit;
         if (up_req_valid && !up_req_ready) pend_q <= 1'b1;
         else if (up_retry)                 pend_q <= 1'b0;
      end
   end

   assign up_retry     = pend_q && space_ok;
   assign up_range_err = err_q;

   p_rsp_in_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cnt <= resv_lvl);
   p_retry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      up_retry |=> !up_retry);
   p_err_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      up_range_err |-> $past(up_req_valid && up_req_ready));
   p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_cnt == QCW'(REQ_LIMIT)) |-> !req_push);
endmodule

// File: tb/dly_bridge_test.sv
module dly_bridge_test;
   localparam int CLK_P = 10;
   localparam int DELAY = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_req_valid = 1'b0, up_req_write = 1'b0, up_req_needs_resp = 1'b0;
   logic [15:0] up_req_addr = '0;
   logic [31:0] up_req_data = '0;
   logic        up_req_ready, up_retry, up_range_err;
   logic        dn_req_valid, dn_req_write, dn_req_needs_resp;
   logic        dn_req_ready = 1'b0;
   logic [15:0] dn_req_addr;
   logic [31:0] dn_req_data;
   logic        dn_rsp_valid = 1'b0, dn_rsp_write = 1'b0, dn_rsp_ready;
   logic [15:0] dn_rsp_addr = '0;
   logic [31:0] dn_rsp_data = '0;
   logic        up_rsp_valid, up_rsp_write;
   logic        up_rsp_ready = 1'b0;
   logic [15:0] up_rsp_addr;
   logic [31:0] up_rsp_data;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   dly_bridge uut (.*);

   // {addr, expected hit}
   localparam logic [16:0] VEC [8] = '{
      {16'h0000, 1'b1}, {16'h0FFF, 1'b1}, {16'h1000, 1'b0}, {16'h7FFF, 1'b0},
      {16'h8000, 1'b1}, {16'h80FF, 1'b1}, {16'h8100, 1'b0}, {16'hFFFF, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the first falling edge after the taking edge
   task automatic put_req(input logic [15:0] a, input logic w, input logic nr, input logic [31:0] d);
      up_req_valid = 1'b1; up_req_addr = a; up_req_write = w;
      up_req_needs_resp = nr; up_req_data = d;
      #1;
      while (!up_req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      up_req_valid = 1'b0;
   endtask

   task automatic pop_dn(input string tag, input logic [31:0] exp_d);
      while (!dn_req_valid) @(negedge clk);
      chk(tag, dn_req_data, exp_d);
      dn_req_ready = 1'b1;
      @(negedge clk);
      dn_req_ready = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R11 reset state
      chk("R11 dn_req_valid", dn_req_valid, 0);
      chk("R11 up_rsp_valid", up_rsp_valid, 0);
      chk("R11 up_req_ready", up_req_ready, 1);
      chk("R11 up_retry", up_retry, 0);
      chk("R11 up_range_err", up_range_err, 0);
      @(negedge clk);

      // R8 / R9 / R1 : window table
      for (int i = 0; i < 8; i++) begin
         put_req(VEC[i][16:1], 1'b1, 1'b0, 32'h100 + i);
         if (VEC[i][0]) begin
            chk("R1 early neg1", dn_req_valid, 0);
            @(negedge clk); chk("R1 early neg2", dn_req_valid, 0);
            @(negedge clk); chk("R1 R8 due", dn_req_valid, 1);
            chk("R8 addr", dn_req_addr, VEC[i][16:1]);
            chk("R8 data", dn_req_data, 32'h100 + i);
            dn_req_ready = 1'b1; @(negedge clk); dn_req_ready = 1'b0;
            chk("R10 drained", dn_req_valid, 0);
         end else begin
            chk("R9 err pulse", up_range_err, 1);
            @(negedge clk); chk("R9 err one cycle", up_range_err, 0);
            for (int k = 0; k < 4; k++) begin
               chk("R9 not forwarded", dn_req_valid, 0);
               @(negedge clk);
            end
         end
      end

      // R4 / R5 / R6 / R9 / R2 / R10 : reservation and response path
      put_req(16'h0010, 1'b0, 1'b1, 32'h11);
      put_req(16'h0020, 1'b0, 1'b1, 32'h22);
      up_req_valid = 1'b0; up_req_needs_resp = 1'b0; up_req_addr = 16'h0030; #1;
      chk("R4 no-resp unaffected", up_req_ready, 1);
      up_req_needs_resp = 1'b1; #1;
      chk("R4 needs-resp refused", up_req_ready, 0);
      up_req_valid = 1'b1;
      @(negedge clk);
      up_req_valid = 1'b0;
      chk("R6 no retry while full", up_retry, 0);
      put_req(16'h5000, 1'b0, 1'b1, 32'h55);
      chk("R9 miss taken at limit", up_range_err, 1);
      pop_dn("R10 req order 0", 32'h11);
      pop_dn("R10 req order 1", 32'h22);
      dn_rsp_valid = 1'b1; dn_rsp_addr = 16'h0010; dn_rsp_data = 32'hA1;
      @(negedge clk);
      chk("R2 rsp early neg1", up_rsp_valid, 0);
      dn_rsp_addr = 16'h0020; dn_rsp_data = 32'hA2;
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      chk("R2 rsp early neg2", up_rsp_valid, 0);
      @(negedge clk);
      chk("R2 rsp due", up_rsp_valid, 1);
      chk("R10 rsp order 0", up_rsp_data, 32'hA1);
      up_req_addr = 16'h0040; up_req_needs_resp = 1'b1; #1;
      chk("R5 held while queued", up_req_ready, 0);
      chk("R6 no retry before release", up_retry, 0);
      up_rsp_ready = 1'b1;
      @(negedge clk);
      up_rsp_ready = 1'b0;
      chk("R6 retry pulse", up_retry, 1);
      chk("R10 rsp order 1", up_rsp_data, 32'hA2);
      #1;
      chk("R5 R9 one slot freed", up_req_ready, 1);
      @(negedge clk);
      chk("R6 retry single cycle", up_retry, 0);
      up_rsp_ready = 1'b1;
      @(negedge clk);
      up_rsp_ready = 1'b0;
      chk("R10 rsp drained", up_rsp_valid, 0);

      // R3 / R7 / R6 : request queue full
      for (int k = 0; k < 4; k++) put_req(16'h0100 + 16'(k), 1'b1, 1'b0, 32'h40 + k);
      up_req_needs_resp = 1'b0; up_req_addr = 16'h0200; #1;
      chk("R3 full refuses", up_req_ready, 0);
      up_req_valid = 1'b1;
      @(negedge clk);
      up_req_valid = 1'b0;
      while (!dn_req_valid) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         chk("R7 head held valid", dn_req_valid, 1);
         chk("R7 head held data", dn_req_data, 32'h40);
         @(negedge clk);
      end
      chk("R6 no retry while full", up_retry, 0);
      dn_req_ready = 1'b1;
      @(negedge clk);
      dn_req_ready = 1'b0;
      chk("R3 R6 retry after pop", up_retry, 1);
      chk("R10 next head", dn_req_data, 32'h41);
      @(negedge clk);
      chk("R6 retry single cycle", up_retry, 0);
      pop_dn("R10 order 2", 32'h41);
      pop_dn("R10 order 3", 32'h42);
      pop_dn("R10 order 4", 32'h43);
      chk("R10 queue empty", dn_req_valid, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule